// File: doc/BRIEF.md
# Host-written VGA framebuffer with raster scan-out

This block keeps a full frame of pixels in on-chip block memory and sends it continuously to a monitor as RGB levels with horizontal and vertical sync. A processor fills the frame one pixel at a time. It drives a packed coordinate word, a pixel value and a write-enable level. The block captures each write on the rising edge of write-enable and commits it in the next write slot. Coordinates that fall outside the visible area are discarded.

The block runs on a clock at twice the pixel rate. Each pixel slot is two clock cycles long. The first cycle of a slot belongs to the display, which reads the memory. The second cycle belongs to the host, which may write. Because of this, display reads never stall, and a host write waits at most one slot. Write address bits [YW-1:0] carry Y (rows, downward from the top edge) and the bits above carry X (columns, rightward from the left edge). Pixel (0,0) is the top-left corner. Memory is indexed linearly as Y*H_VIS+X, so no storage is spent on the gaps in the packed address space.

A stored pixel is either 8 bits wide, coded as red/green/blue 3:3:2, or 1 bit wide for black and white. The 640x480 60 Hz mode uses H_VIS=640, H_FP=16, H_SYNC=96, H_BP=48, V_VIS=480, V_FP=10, V_SYNC=2, V_BP=33, with a 50 MHz clock. The defaults are a small geometry so that the memory elaborates small.

Top module: `vga_fb_scan`

## Requirements
- R1: While reset is asserted, the RGB outputs are 0, both syncs are high, and vid_active is 0.
- R2: Each raster position lasts two clock cycles. A line is H_VIS+H_FP+H_SYNC+H_BP positions long. After reset, slot k (clock cycles 2k and 2k+1) shows raster position k-1, and slot 0 still shows the reset values. vga_hs_n is low for the H_SYNC positions that start at column H_VIS+H_FP.
- R3: A frame is V_VIS+V_FP+V_SYNC+V_BP lines. vga_vs_n is low for the V_SYNC lines that start at line V_VIS+V_FP.
- R4: A write to address {x, y}, with y in bits [YW-1:0] and x in the bits above, appears at column x of line y. Column 0 of line 0 is the first visible position of a frame.
- R5: With PIX_W=8, a pixel p is shown as red {p[7:5],p[7:5],p[7:6]}, green {p[4:2],p[4:2],p[4:3]} and blue {p[1:0] repeated four times}.
- R6: Outside the visible area, vid_active is 0 and all RGB outputs are 0.
- R7: A write with x >= H_VIS or y >= V_VIS leaves every pixel unchanged. This includes the pixel that the same linear index would alias onto.
- R8: Only a rising edge of wr_en starts a write. Address and data changes while wr_en stays high are ignored.
- R9: Display reads keep every slot. A captured write is committed within two cycles. Writes strobed every two cycles (one cycle high, one cycle low) are all kept.
- R10: With PIX_W=1, bit 0 of the write data selects all RGB outputs at 8'hFF or at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, twice the pixel rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_addr | input | XW+YW | Packed coordinate word: X in the upper bits, Y in the low YW bits |
| wr_data | input | PIX_W | Pixel value to store |
| wr_en | input | 1 | Write-enable level; a rising edge requests one write |
| vga_r | output | 8 | Red level |
| vga_g | output | 8 | Green level |
| vga_b | output | 8 | Blue level |
| vga_hs_n | output | 1 | Horizontal sync, active low |
| vga_vs_n | output | 1 | Vertical sync, active low |
| vid_active | output | 1 | High during visible positions |

## Verification
The frame is first filled with a coordinate-dependent pattern, so a swapped or misaligned X/Y decode shows up as wrong colours at known places. Directed writes come next: the four corners with pure primary colours, which separate an origin or field error from a colour-expansion error. They are followed by out-of-range writes, one of which aliases onto a valid linear index, and by a held strobe whose address changes while it is high. Last comes a burst of random writes at the fastest strobe rate, mixed with invalid coordinates, to expose a write that is lost while the display holds the memory. Each of these phases ends with a whole frame compared slot by slot against a shadow copy, on an 8-bit and a 1-bit instance in parallel. Sync and blanking are compared against the raster position on every slot.

// File: rtl/vfb_pkg.sv
package vfb_pkg;
  typedef struct packed {
    logic [7:0] r;
    logic [7:0] g;
    logic [7:0] b;
  } rgb_t;
endpackage

// File: rtl/vfb_timing.sv
module vfb_timing #(
  parameter int H_VIS  = 40,
  parameter int H_FP   = 4,
  parameter int H_SYNC = 8,
  parameter int H_BP   = 6,
  parameter int V_VIS  = 30,
  parameter int V_FP   = 2,
  parameter int V_SYNC = 2,
  parameter int V_BP   = 3,
  localparam int H_TOT = H_VIS + H_FP + H_SYNC + H_BP,
  localparam int V_TOT = V_VIS + V_FP + V_SYNC + V_BP,
  localparam int HCW   = $clog2(H_TOT),
  localparam int VCW   = $clog2(V_TOT)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           adv,
  output logic [HCW-1:0] hcnt,
  output logic [VCW-1:0] vcnt,
  output logic           active,
  output logic           hsync,
  output logic           vsync
);
  localparam logic [HCW-1:0] H_LAST  = HCW'(H_TOT - 1);
  localparam logic [VCW-1:0] V_LAST  = VCW'(V_TOT - 1);
  localparam logic [HCW-1:0] H_VLIM  = HCW'(H_VIS);
  localparam logic [VCW-1:0] V_VLIM  = VCW'(V_VIS);
  localparam logic [HCW-1:0] HS_BEG  = HCW'(H_VIS + H_FP);
  localparam logic [HCW-1:0] HS_END  = HCW'(H_VIS + H_FP + H_SYNC);
  localparam logic [VCW-1:0] VS_BEG  = VCW'(V_VIS + V_FP);
  localparam logic [VCW-1:0] VS_END  = VCW'(V_VIS + V_FP + V_SYNC);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hcnt <= '0;
      vcnt <= '0;
    end else if (adv) begin
      if (hcnt == H_LAST) begin
        hcnt <= '0;
        vcnt <= (vcnt == V_LAST) ? '0 : vcnt + 1'b1;
      end else begin
        hcnt <= hcnt + 1'b1;
      end
    end
  end

  always_comb begin
    active = (hcnt < H_VLIM) && (vcnt < V_VLIM);
    hsync  = (hcnt >= HS_BEG) && (hcnt < HS_END);
    vsync  = (vcnt >= VS_BEG) && (vcnt < VS_END);
  end
endmodule

// File: rtl/vfb_host_port.sv
module vfb_host_port #(
  parameter int XW    = 10,
  parameter int YW    = 9,
  parameter int H_VIS = 40,
  parameter int V_VIS = 30,
  parameter int DW    = 8,
  parameter int AW    = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [XW+YW-1:0] wr_addr,
  input  logic [DW-1:0]    wr_data,
  input  logic             wr_en,
  input  logic             commit,
  output logic             pend,
  output logic [AW-1:0]    pend_idx,
  output logic [DW-1:0]    pend_data
);
  localparam logic [XW-1:0] X_LIM = XW'(H_VIS);
  localparam logic [YW-1:0] Y_LIM = YW'(V_VIS);

  logic          en_q;
  logic          rise;
  logic          in_range;
  logic [XW-1:0] px;
  logic [YW-1:0] py;
  logic [AW-1:0] lin;

  always_comb begin
    px       = wr_addr[XW+YW-1:YW];
    py       = wr_addr[YW-1:0];
    rise     = wr_en && !en_q;
    in_range = (px < X_LIM) && (py < Y_LIM);
    lin      = AW'(py) * AW'(H_VIS) + AW'(px);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q      <= 1'b0;
      pend      <= 1'b0;
      pend_idx  <= '0;
      pend_data <= '0;
    end else begin
      en_q <= wr_en;
      if (rise && in_range) begin
        pend      <= 1'b1;
        pend_idx  <= lin;
        pend_data <= wr_data;
      end else if (commit) begin
        pend <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/vfb_ram.sv
module vfb_ram #(
  parameter int DEPTH = 1200,
  parameter int DW    = 8,
  parameter int AW    = 11
) (
  input  logic          clk,
  input  logic          en,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (en) begin
      if (we) mem[addr] <= wdata;
      else    rdata     <= mem[addr];
    end
  end
endmodule

// File: rtl/vfb_colour.sv
module vfb_colour #(
  parameter int DW = 8
) (
  input  logic [DW-1:0]     pix,
  output vfb_pkg::rgb_t     rgb
);
  generate
    if (DW == 1) begin : g_mono
      always_comb begin
        rgb.r = {8{pix[0]}};
        rgb.g = {8{pix[0]}};
        rgb.b = {8{pix[0]}};
      end
    end else begin : g_332
      logic [7:0] p8;
      always_comb begin
        p8    = pix[DW-1 -: 8];
        rgb.r = {p8[7:5], p8[7:5], p8[7:6]};
        rgb.g = {p8[4:2], p8[4:2], p8[4:3]};
        rgb.b = {4{p8[1:0]}};
      end
    end
  endgenerate
endmodule

// File: rtl/vga_fb_scan.sv
module vga_fb_scan #(
  parameter int H_VIS  = 40,
  parameter int H_FP   = 4,
  parameter int H_SYNC = 8,
  parameter int H_BP   = 6,
  parameter int V_VIS  = 30,
  parameter int V_FP   = 2,
  parameter int V_SYNC = 2,
  parameter int V_BP   = 3,
  parameter int XW     = 10,
  parameter int YW     = 9,
  parameter int PIX_W  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [XW+YW-1:0] wr_addr,
  input  logic [PIX_W-1:0] wr_data,
  input  logic             wr_en,
  output logic [7:0]       vga_r,
  output logic [7:0]       vga_g,
  output logic [7:0]       vga_b,
  output logic             vga_hs_n,
  output logic             vga_vs_n,
  output logic             vid_active
);
  localparam int DEPTH = H_VIS * V_VIS;
  localparam int AW    = $clog2(DEPTH);
  localparam int H_TOT = H_VIS + H_FP + H_SYNC + H_BP;
  localparam int V_TOT = V_VIS + V_FP + V_SYNC + V_BP;
  localparam int HCW   = $clog2(H_TOT);
  localparam int VCW   = $clog2(V_TOT);

  // slot phase: 0 = display read cycle, 1 = host write cycle
  logic             phase;
  logic [HCW-1:0]   hcnt;
  logic [VCW-1:0]   vcnt;
  logic             t_active, t_hs, t_vs;
  logic             pend;
  logic [AW-1:0]    pend_idx;
  logic [PIX_W-1:0] pend_data;
  logic             rd_en, ram_we, ram_en;
  logic [AW-1:0]    rd_idx, ram_addr;
  logic [PIX_W-1:0] rdata;
  vfb_pkg::rgb_t    pix_rgb;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase <= 1'b0;
    else        phase <= ~phase;
  end

  vfb_timing #(
    .H_VIS(H_VIS), .H_FP(H_FP), .H_SYNC(H_SYNC), .H_BP(H_BP),
    .V_VIS(V_VIS), .V_FP(V_FP), .V_SYNC(V_SYNC), .V_BP(V_BP)
  ) u_timing (
    .clk(clk), .rst_n(rst_n), .adv(phase),
    .hcnt(hcnt), .vcnt(vcnt),
    .active(t_active), .hsync(t_hs), .vsync(t_vs)
  );

  vfb_host_port #(
    .XW(XW), .YW(YW), .H_VIS(H_VIS), .V_VIS(V_VIS), .DW(PIX_W), .AW(AW)
  ) u_host (
    .clk(clk), .rst_n(rst_n),
    .wr_addr(wr_addr), .wr_data(wr_data), .wr_en(wr_en),
    .commit(ram_we),
    .pend(pend), .pend_idx(pend_idx), .pend_data(pend_data)
  );

  always_comb begin
    rd_idx   = AW'(vcnt) * AW'(H_VIS) + AW'(hcnt);
    rd_en    = !phase && t_active;
    ram_we   = phase && pend;
    ram_en   = rd_en || ram_we;
    ram_addr = ram_we ? pend_idx : rd_idx;
  end

  vfb_ram #(.DEPTH(DEPTH), .DW(PIX_W), .AW(AW)) u_ram (
    .clk(clk), .en(ram_en), .we(ram_we),
    .addr(ram_addr), .wdata(pend_data), .rdata(rdata)
  );

  vfb_colour #(.DW(PIX_W)) u_colour (
    .pix(rdata), .rgb(pix_rgb)
  );

  // output stage updates at the end of each slot
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vga_r      <= '0;
      vga_g      <= '0;
      vga_b      <= '0;
      vga_hs_n   <= 1'b1;
      vga_vs_n   <= 1'b1;
      vid_active <= 1'b0;
    end else if (phase) begin
      vga_r      <= t_active ? pix_rgb.r : 8'd0;
      vga_g      <= t_active ? pix_rgb.g : 8'd0;
      vga_b      <= t_active ? pix_rgb.b : 8'd0;
      vga_hs_n   <= !t_hs;
      vga_vs_n   <= !t_vs;
      vid_active <= t_active;
    end
  end
endmodule

// File: rtl/vfb_checker.sv
module vfb_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       phase,
  input logic       rd_en,
  input logic       ram_we,
  input logic       pend,
  input logic [7:0] vga_r,
  input logic [7:0] vga_g,
  input logic [7:0] vga_b,
  input logic       vga_hs_n,
  input logic       vga_vs_n,
  input logic       vid_active
);
  AST_BLANK_BLACK: assert property (@(posedge clk) disable iff (!rst_n)
    !vid_active |-> ({vga_r, vga_g, vga_b} == 24'd0)); // R6

  AST_SLOT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    phase |-> $stable({vga_r, vga_g, vga_b, vga_hs_n, vga_vs_n, vid_active})); // R2

  AST_HS_IN_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
    !vga_hs_n |-> !vid_active); // R2

  AST_VS_IN_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
    !vga_vs_n |-> !vid_active); // R3

  AST_WRITE_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> (phase && !rd_en)); // R9

  AST_WRITE_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && !ram_we) |=> ram_we); // R9
endmodule

bind vga_fb_scan vfb_checker u_chk (
  .clk(clk), .rst_n(rst_n), .phase(phase), .rd_en(rd_en),
  .ram_we(ram_we), .pend(pend),
  .vga_r(vga_r), .vga_g(vga_g), .vga_b(vga_b),
  .vga_hs_n(vga_hs_n), .vga_vs_n(vga_vs_n), .vid_active(vid_active)
);

// File: tb/tb_vga_fb_scan.sv
module tb_vga_fb_scan;
  localparam int HV = 40, HFP = 4, HS = 8, HBP = 6;
  localparam int VV = 30, VFP = 2, VS = 2, VBP = 3;
  localparam int HT = HV + HFP + HS + HBP;
  localparam int VT = VV + VFP + VS + VBP;
  localparam int FT = HT * VT;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [18:0] wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic        wr_en = 1'b0;
  logic [7:0]  r8, g8, b8, r1, g1, b1;
  logic        hs8, vs8, act8, hs1, vs1, act1;

  int compared = 0;
  int mismatched = 0;
  int edges = 0;
  logic live = 1'b0;
  int req_cnt = 0;
  int done_cnt = 0;
  logic rgb_on = 1'b0;
  int rgb_left = 0;
  string frame_tag = "R4";
  logic [7:0] shadow [HV*VV];

  always #5 clk = ~clk;

  vga_fb_scan #(.H_VIS(HV), .H_FP(HFP), .H_SYNC(HS), .H_BP(HBP),
                .V_VIS(VV), .V_FP(VFP), .V_SYNC(VS), .V_BP(VBP),
                .XW(10), .YW(9), .PIX_W(8)) dut (
    .clk(clk), .rst_n(rst_n), .wr_addr(wr_addr), .wr_data(wr_data), .wr_en(wr_en),
    .vga_r(r8), .vga_g(g8), .vga_b(b8), .vga_hs_n(hs8), .vga_vs_n(vs8), .vid_active(act8));

  vga_fb_scan #(.H_VIS(HV), .H_FP(HFP), .H_SYNC(HS), .H_BP(HBP),
                .V_VIS(VV), .V_FP(VFP), .V_SYNC(VS), .V_BP(VBP),
                .XW(10), .YW(9), .PIX_W(1)) dut_mono (
    .clk(clk), .rst_n(rst_n), .wr_addr(wr_addr), .wr_data(wr_data[0:0]), .wr_en(wr_en),
    .vga_r(r1), .vga_g(g1), .vga_b(b1), .vga_hs_n(hs1), .vga_vs_n(vs1), .vid_active(act1));

  function automatic logic [23:0] exp332(input logic [7:0] p);
    return {p[7:5], p[7:5], p[7:6], p[4:2], p[4:2], p[4:3], {4{p[1:0]}}};
  endfunction

  task automatic check(input logic ok, input string tag, input logic [23:0] act,
                       input logic [23:0] exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h at edge %0d", tag, act, exp, edges);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      edges <= 0;
      live  <= 1'b0;
    end else begin
      edges <= edges + 1;
      live  <= 1'b1;
    end
  end

  // slot monitor: slot s shows raster position s-1
  always @(negedge clk) begin
    if (live && rst_n && (edges % 2 == 0) && edges >= 2) begin
      int p, h, v;
      logic eh, ev, ea;
      logic [23:0] e8, e1;
      p  = edges / 2 - 1;
      h  = p % HT;
      v  = (p / HT) % VT;
      ea = (h < HV) && (v < VV);
      eh = !((h >= HV + HFP) && (h < HV + HFP + HS));
      ev = !((v >= VV + VFP) && (v < VV + VFP + VS));
      check(hs8 == eh && hs1 == eh, "R2 hsync", {22'd0, hs8, hs1}, {22'd0, eh, eh});
      check(vs8 == ev && vs1 == ev, "R3 vsync", {22'd0, vs8, vs1}, {22'd0, ev, ev});
      check(act8 == ea && act1 == ea, "R6 active", {22'd0, act8, act1}, {22'd0, ea, ea});
      if (!ea)
        check({r8, g8, b8} == 24'd0 && {r1, g1, b1} == 24'd0, "R6 blank rgb",
              {r8, g8, b8}, 24'd0);
      if (!rgb_on && done_cnt != req_cnt && h == 0 && v == 0) begin
        rgb_on   = 1'b1;
        rgb_left = FT;
      end
      if (rgb_on) begin
        if (ea) begin
          e8 = exp332(shadow[v * HV + h]);
          e1 = {24{shadow[v * HV + h][0]}};
          check({r8, g8, b8} == e8, frame_tag, {r8, g8, b8}, e8);
          check({r1, g1, b1} == e1, "R10 mono", {r1, g1, b1}, e1);
        end
        rgb_left--;
        if (rgb_left == 0) begin
          rgb_on = 1'b0;
          done_cnt++;
        end
      end
    end
  end

  task automatic host_write(input int x, input int y, input logic [7:0] d);
    @(negedge clk);
    wr_addr = {10'(x), 9'(y)};
    wr_data = d;
    wr_en   = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    if (x < HV && y < VV) shadow[y * HV + x] = d;
  endtask

  task automatic check_frame(input string tag);
    frame_tag = tag;
    req_cnt++;
    wait (done_cnt == req_cnt);
  endtask

  initial begin
    void'($urandom(32'd4711));
    repeat (4) @(negedge clk);
    // R1: reset values
    check({r8, g8, b8, r1, g1, b1} == 48'd0, "R1 rgb", {r8, g8, b8}, 24'd0);
    check(hs8 && vs8 && hs1 && vs1 && !act8 && !act1, "R1 sync",
          {19'd0, hs8, vs8, hs1, vs1, act8}, {19'd0, 5'b11110});
    @(negedge clk);
    rst_n = 1'b1;

    // fill with coordinate pattern (R4, R5)
    for (int y = 0; y < VV; y++)
      for (int x = 0; x < HV; x++)
        host_write(x, y, 8'((x * 37 + y * 11) ^ (y << 5)));
    check_frame("R4/R5 pattern");

    // corners, invalid coordinates, held strobe
    host_write(0, 0, 8'hE0);
    host_write(HV - 1, 0, 8'h1C);
    host_write(0, VV - 1, 8'h03);
    host_write(HV - 1, VV - 1, 8'hFF);
    host_write(HV, 0, 8'h55);        // R7 x out of range
    host_write(HV + 5, 0, 8'h55);    // R7 would alias to (5,1)
    host_write(0, VV, 8'h55);        // R7 y out of range
    host_write(1023, 511, 8'h55);    // R7 both out of range
    @(negedge clk);
    wr_addr = {10'd10, 9'd10};
    wr_data = 8'hA5;
    wr_en   = 1'b1;
    shadow[10 * HV + 10] = 8'hA5;
    @(negedge clk);
    wr_addr = {10'd11, 9'd10};       // R8 change while held high
    wr_data = 8'h5A;
    repeat (3) @(negedge clk);
    wr_en = 1'b0;
    @(negedge clk);
    check_frame("R7/R8 directed");

    // fastest strobe rate, random coordinates with invalid ones mixed in (R9)
    for (int i = 0; i < 400; i++) begin
      int x, y;
      x = ($urandom % 4 == 0) ? HV + int'($urandom % 100) : int'($urandom % HV);
      y = ($urandom % 5 == 0) ? VV + int'($urandom % 50) : int'($urandom % VV);
      host_write(x, y, 8'($urandom));
    end
    repeat (4) @(negedge clk);
    check_frame("R9 burst");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    mismatched++;
    compared++;
    $display("FAIL watchdog expired: actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule